// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Aligner

This block is the instruction window of one hardware thread. The fetch unit hands it fixed 64-bit words. Each word carries a free mix of 16-bit and 32-bit instructions. The window splits that stream back into single instructions and presents at most one instruction per cycle to the issue stage, together with a flag that gives its length. A 32-bit instruction may begin in the last halfword of one fetch word and finish in the first halfword of the next. The window therefore keeps leftover halfwords between words, and it holds back a partial instruction until its second half has arrived.

In the same cycle as it hands out an instruction, the window tells the fetch unit whether it wants another word. It asks whenever fewer than one fetch word of halfwords would be left at the end of the cycle. A redirect flush empties the window and records how many leading halfwords of the next accepted word to discard, so that execution can resume at any halfword inside a word. Decoding goes no further than the length bit.

Top module: `insn_align_window`

## Requirements
- R1: Halfword k of a fetch word sits in bits [16k+15:16k]. Lower k comes earlier in program order, and halfwords from one accepted word follow all halfwords from earlier words.
- R2: Bit 0 of an instruction's first halfword set to 1 marks a 32-bit instruction, and `insn_long` is then 1. A 32-bit instruction appears as {second halfword, first halfword}. A 16-bit instruction appears with bits [31:16] zero.
- R3: `insn_valid` is 1 only when every halfword of the head instruction is buffered. A 32-bit instruction whose first half is the only halfword held is not presented.
- R4: `consume` while `insn_valid` is 1 removes exactly the presented instruction at the clock edge. `consume` while `insn_valid` is 0 changes nothing.
- R5: While the head instruction is valid and neither consumed nor flushed, its length flag and first halfword stay unchanged in the next cycle.
- R6: `fetch_req` is 1 exactly when `flush` is 1, or when the halfwords left after this cycle's consume, plus those of a word accepted this cycle, number fewer than 4.
- R7: The window holds at most 8 halfwords. A fetch word whose halfwords would not fit after this cycle's consume is dropped whole and leaves no trace.
- R8: `flush` empties the window at the clock edge. A consume or a fetch word presented in the flush cycle is ignored, and no instruction is valid in the cycle after.
- R9: After a flush with offset s (0 to 3), the first halfwords 0..s-1 of the next accepted word are discarded. Words after that one are taken whole.
- R10: After reset the window is empty: `insn_valid` is 0 and `fetch_req` is 1.
- R11: Every instruction that is packed into the fetch words comes out exactly once, unchanged and in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | A fetch word is present on `fetch_data` |
| fetch_data | input | 64 | Fetch word, four halfwords, lowest first |
| consume | input | 1 | Issue stage takes the presented instruction |
| flush | input | 1 | Redirect: discard all buffered halfwords |
| flush_ofs | input | 2 | Halfwords to skip in the next accepted word |
| insn_valid | output | 1 | Head instruction complete and presented |
| insn_data | output | 32 | Head instruction (16-bit ones zero-extended) |
| insn_long | output | 1 | Head instruction is 32 bits long |
| fetch_req | output | 1 | Window wants a fetch word in the next cycle |

## Verification
The bench builds the block with its default parameters: 64-bit words, 16-bit halfwords, a two-word window, a long-marker bit of 1 and zero-filled short instructions. With only four halfwords per word, a 32-bit instruction lands across a word boundary every few words, a third word arriving without any consume hits the full-window drop, and each of the four flush offsets is reached many times. Because the window holds just eight halfwords, random stalls of the issue stage keep it near empty and near full in turn, so the request rule and the drop rule are both exercised at their edges.

// File: rtl/ialign_pkg.sv
package ialign_pkg;

   // Head-of-window decode result
   typedef struct packed {
      logic valid;
      logic is_long;
   } head_t;

   // True when the length bit of a first halfword marks a 32-bit instruction
   function automatic logic marks_long(input logic len_bit, input logic mark);
      return len_bit == mark;
   endfunction

endpackage

// File: rtl/ialign_len_decode.sv
module ialign_len_decode
   import ialign_pkg::*;
#(
   parameter int HW_W      = 16,
   parameter int CNT_W     = 4,
   parameter bit LONG_MARK = 1'b1,
   parameter bit ZERO_FILL = 1'b1
) (
   input  logic [HW_W-1:0]   head_lo,
   input  logic [HW_W-1:0]   head_hi,
   input  logic [CNT_W-1:0]  count,
   input  logic              consume,
   input  logic              flush,
   output head_t             head,
   output logic [1:0]        take,
   output logic [2*HW_W-1:0] data
);

   logic [CNT_W-1:0] need;

   always_comb begin
      head.is_long = marks_long(head_lo[0], LONG_MARK);
      need         = head.is_long ? CNT_W'(2) : CNT_W'(1);
      head.valid   = (count >= need);
      if (head.valid && consume && !flush)
         take = head.is_long ? 2'd2 : 2'd1;
      else
         take = 2'd0;
   end

   generate
      if (ZERO_FILL) begin : g_zero_fill
         assign data = head.is_long ? {head_hi, head_lo} : {{HW_W{1'b0}}, head_lo};
      end else begin : g_raw_pair
         assign data = {head_hi, head_lo};
      end
   endgenerate

endmodule

// File: rtl/ialign_fetch_ctrl.sv
module ialign_fetch_ctrl #(
   parameter int HW_PER_WORD = 4,
   parameter int BUF_HW      = 8,
   parameter int CNT_W       = 4,
   parameter int OFS_W       = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [1:0]       take,
   input  logic             fetch_valid,
   input  logic             flush,
   input  logic [OFS_W-1:0] flush_ofs,
   output logic [CNT_W-1:0] inc,
   output logic [OFS_W-1:0] skip,
   output logic             fetch_req
);

   localparam int SUM_W = CNT_W + 1;

   logic [OFS_W-1:0] skip_q;
   logic [SUM_W-1:0] remain;
   logic [SUM_W-1:0] word_hw;
   logic [SUM_W-1:0] after;
   logic             fits;
   logic             accept;

   always_comb begin
      remain    = SUM_W'(count) - SUM_W'(take);
      word_hw   = SUM_W'(HW_PER_WORD) - SUM_W'(skip_q);
      fits      = (remain + word_hw) <= SUM_W'(BUF_HW);
      accept    = fetch_valid && !flush && fits;
      after     = remain + (accept ? word_hw : '0);
      fetch_req = flush || (after < SUM_W'(HW_PER_WORD));
      inc       = accept ? CNT_W'(word_hw) : '0;
   end

   assign skip = skip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         skip_q <= '0;
      end else if (flush) begin
         skip_q <= flush_ofs;
      end else if (accept) begin
         skip_q <= '0;
      end
   end

endmodule

// File: rtl/ialign_shift_buf.sv
module ialign_shift_buf #(
   parameter int FETCH_W     = 64,
   parameter int HW_W        = 16,
   parameter int HW_PER_WORD = 4,
   parameter int BUF_HW      = 8,
   parameter int CNT_W       = 4,
   parameter int OFS_W       = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [1:0]         take,
   input  logic [CNT_W-1:0]   inc,
   input  logic [OFS_W-1:0]   skip,
   input  logic [FETCH_W-1:0] word,
   output logic [HW_W-1:0]    head_lo,
   output logic [HW_W-1:0]    head_hi,
   output logic [CNT_W-1:0]   count
);

   logic [HW_W-1:0]  slot_q  [BUF_HW];
   logic [HW_W-1:0]  slot_d  [BUF_HW];
   logic [HW_W-1:0]  word_hw [HW_PER_WORD];
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_d;
   logic [CNT_W-1:0] remain;

   genvar g;
   generate
      for (g = 0; g < HW_PER_WORD; g++) begin : g_split
         assign word_hw[g] = word[g*HW_W +: HW_W];
      end
   endgenerate

   // Slot j keeps old slot j+take while below the remaining count,
   // then takes halfword (j - remain + skip) of the arriving word.
   always_comb begin
      remain  = count_q - CNT_W'(take);
      count_d = flush ? '0 : (remain + inc);
      for (int j = 0; j < BUF_HW; j++) begin
         slot_d[j] = slot_q[j];
         for (int k = 0; k < BUF_HW; k++) begin
            if (j < int'(remain) && k == j + int'(take))
               slot_d[j] = slot_q[k];
         end
         for (int k = 0; k < HW_PER_WORD; k++) begin
            if (j >= int'(remain) && j < int'(remain) + int'(inc) &&
                k == j - int'(remain) + int'(skip))
               slot_d[j] = word_hw[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         for (int j = 0; j < BUF_HW; j++) slot_q[j] <= '0;
      end else begin
         count_q <= count_d;
         for (int j = 0; j < BUF_HW; j++) slot_q[j] <= slot_d[j];
      end
   end

   assign head_lo = slot_q[0];
   assign head_hi = slot_q[1];
   assign count   = count_q;

endmodule

// File: rtl/insn_align_window.sv
module insn_align_window
   import ialign_pkg::*;
#(
   parameter int FETCH_W   = 64,
   parameter int HW_W      = 16,
   parameter int BUF_WORDS = 2,
   parameter bit LONG_MARK = 1'b1,
   parameter bit ZERO_FILL = 1'b1,
   localparam int HW_PER_WORD = FETCH_W / HW_W,
   localparam int BUF_HW      = HW_PER_WORD * BUF_WORDS,
   localparam int CNT_W       = $clog2(BUF_HW + 1),
   localparam int OFS_W       = (HW_PER_WORD > 1) ? $clog2(HW_PER_WORD) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fetch_valid,
   input  logic [FETCH_W-1:0] fetch_data,
   input  logic               consume,
   input  logic               flush,
   input  logic [OFS_W-1:0]   flush_ofs,
   output logic               insn_valid,
   output logic [2*HW_W-1:0]  insn_data,
   output logic               insn_long,
   output logic               fetch_req
);

   initial begin
      assert (FETCH_W % HW_W == 0)
         else $fatal(1, "fetch width must be a whole number of halfwords");
      assert (HW_PER_WORD >= 2 && (HW_PER_WORD & (HW_PER_WORD - 1)) == 0)
         else $fatal(1, "halfwords per word must be a power of two, at least 2");
      assert (BUF_WORDS >= 2)
         else $fatal(1, "window must hold at least two fetch words");
   end

   head_t            head;
   logic [1:0]       take;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] inc;
   logic [OFS_W-1:0] skip;
   logic [HW_W-1:0]  head_lo;
   logic [HW_W-1:0]  head_hi;

   ialign_shift_buf #(
      .FETCH_W     (FETCH_W),
      .HW_W        (HW_W),
      .HW_PER_WORD (HW_PER_WORD),
      .BUF_HW      (BUF_HW),
      .CNT_W       (CNT_W),
      .OFS_W       (OFS_W)
   ) i_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .take    (take),
      .inc     (inc),
      .skip    (skip),
      .word    (fetch_data),
      .head_lo (head_lo),
      .head_hi (head_hi),
      .count   (count)
   );

   ialign_len_decode #(
      .HW_W      (HW_W),
      .CNT_W     (CNT_W),
      .LONG_MARK (LONG_MARK),
      .ZERO_FILL (ZERO_FILL)
   ) i_dec (
      .head_lo (head_lo),
      .head_hi (head_hi),
      .count   (count),
      .consume (consume),
      .flush   (flush),
      .head    (head),
      .take    (take),
      .data    (insn_data)
   );

   ialign_fetch_ctrl #(
      .HW_PER_WORD (HW_PER_WORD),
      .BUF_HW      (BUF_HW),
      .CNT_W       (CNT_W),
      .OFS_W       (OFS_W)
   ) i_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .count       (count),
      .take        (take),
      .fetch_valid (fetch_valid),
      .flush       (flush),
      .flush_ofs   (flush_ofs),
      .inc         (inc),
      .skip        (skip),
      .fetch_req   (fetch_req)
   );

   assign insn_valid = head.valid;
   assign insn_long  = head.is_long;

endmodule

// File: rtl/ialign_checker.sv
module ialign_checker #(
   parameter int HW_W        = 16,
   parameter int HW_PER_WORD = 4,
   parameter int BUF_HW      = 8,
   parameter int CNT_W       = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              consume,
   input logic              fetch_valid,
   input logic              insn_valid,
   input logic              insn_long,
   input logic [2*HW_W-1:0] insn_data,
   input logic              fetch_req,
   input logic [CNT_W-1:0]  count
);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(BUF_HW)); // R7

   AST_LONG_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_long) |-> count >= CNT_W'(2)); // R3

   AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> !insn_valid); // R3

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !insn_valid); // R8

   AST_REQ_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_valid && count < CNT_W'(HW_PER_WORD)) |-> fetch_req); // R6

   AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && !consume && !flush) |=>
         (insn_valid && insn_long == $past(insn_long) &&
          insn_data[HW_W-1:0] == $past(insn_data[HW_W-1:0]))); // R5

endmodule

bind insn_align_window ialign_checker #(
   .HW_W        (HW_W),
   .HW_PER_WORD (HW_PER_WORD),
   .BUF_HW      (BUF_HW),
   .CNT_W       (CNT_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush       (flush),
   .consume     (consume),
   .fetch_valid (fetch_valid),
   .insn_valid  (insn_valid),
   .insn_long   (insn_long),
   .insn_data   (insn_data),
   .fetch_req   (fetch_req),
   .count       (count)
);

// File: tb/test_insn_align_window.sv
`timescale 1ns/1ps
module test_insn_align_window;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [63:0] fetch_data = '0;
   logic        consume = 1'b0;
   logic        flush = 1'b0;
   logic [1:0]  flush_ofs = '0;
   logic        insn_valid;
   logic [31:0] insn_data;
   logic        insn_long;
   logic        fetch_req;

   always #2 clk = ~clk;

   insn_align_window i_insn_align_window (
      .clk         (clk),
      .rst_n       (rst_n),
      .fetch_valid (fetch_valid),
      .fetch_data  (fetch_data),
      .consume     (consume),
      .flush       (flush),
      .flush_ofs   (flush_ofs),
      .insn_valid  (insn_valid),
      .insn_data   (insn_data),
      .insn_long   (insn_long),
      .fetch_req   (fetch_req)
   );

   typedef struct {
      logic        lng;
      logic [31:0] d;
   } ins_t;

   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   logic [15:0] prog[$];
   ins_t        expq[$];
   logic [15:0] mq[$];
   int          ptr = 0;
   int          skip_m = 0;
   logic        prev_req = 1'b1;
   bit          prev_hold = 1'b0;
   logic [16:0] prev_head = '0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void push_ins(input bit lng, input logic [15:0] a, input logic [15:0] b);
      ins_t r;
      logic [15:0] f;
      f = a;
      f[0] = lng;
      prog.push_back(f);
      if (lng) prog.push_back(b);
      r.lng = lng;
      r.d   = lng ? {b, f} : {16'h0000, f};
      expq.push_back(r);
   endfunction

   function automatic logic [63:0] peek_word();
      logic [63:0] w;
      while (prog.size() < ptr + 4)
         push_ins(bit'($urandom % 2), 16'($urandom), 16'($urandom));
      for (int k = 0; k < 4; k++) w[16*k +: 16] = prog[ptr + k];
      return w;
   endfunction

   // One clock cycle: drive, check outputs against the spec model, update the model
   task automatic cyc(input bit fv, input bit cons, input bit fl, input logic [1:0] ofs);
      bit          ev, elong, fire, acc, ereq;
      int          take, remain, inc;
      logic [31:0] edata;
      ins_t        e;
      @(negedge clk);
      fetch_valid = fv;
      fetch_data  = fv ? peek_word() : {$urandom, $urandom};
      consume     = cons;
      flush       = fl;
      flush_ofs   = ofs;
      #1;
      ev    = (mq.size() >= 1) && (mq[0][0] == 1'b0 || mq.size() >= 2);
      elong = (mq.size() >= 1) && mq[0][0];
      chk("R3 insn_valid", insn_valid, ev);
      if (ev) begin
         chk("R2 insn_long", insn_long, elong);
         edata = elong ? {mq[1], mq[0]} : {16'h0000, mq[0]};
         chk("R1 insn_data", insn_data, edata);
      end
      if (prev_hold) chk("R5 stalled head stable", {insn_long, insn_data[15:0]}, prev_head);
      fire   = ev && cons && !fl;
      take   = fire ? (elong ? 2 : 1) : 0;
      remain = mq.size() - take;
      inc    = 4 - skip_m;
      acc    = fv && !fl && (remain + inc <= 8);
      ereq   = fl || ((remain + (acc ? inc : 0)) < 4);
      chk("R6 fetch_req", fetch_req, ereq);
      prev_hold = ev && !cons && !fl;
      prev_head = {insn_long, insn_data[15:0]};
      if (fire) begin
         repeat (take) void'(mq.pop_front());
         if (expq.size() == 0) begin
            chk("R11 unexpected instruction", 1, 0);
         end else begin
            e = expq.pop_front();
            chk("R4,R11 instruction order", {insn_long, insn_data}, {e.lng, e.d});
         end
      end
      if (fl) begin
         mq.delete();
         skip_m = ofs;
      end else if (acc) begin
         for (int k = skip_m; k < 4; k++) mq.push_back(prog[ptr + k]);
         ptr    = ptr + 4;
         skip_m = 0;
      end
      prev_req = fetch_req;
   endtask

   task automatic do_flush(input int ofs, input bit fv, input bit cons);
      prog.delete();
      expq.delete();
      ptr = 0;
      repeat (ofs) prog.push_back(16'hFFFF);
      cyc(fv, cons, 1'b1, 2'(ofs));
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk("R10 reset insn_valid", insn_valid, 0);
      chk("R10 reset fetch_req", fetch_req, 1);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk); #1;
      chk("R10 empty after reset insn_valid", insn_valid, 0);

      // Straddling 32-bit instruction: three shorts then a long across the boundary
      push_ins(0, 16'h1110, 0); push_ins(0, 16'h2220, 0); push_ins(0, 16'h3330, 0);
      push_ins(1, 16'hA001, 16'hB002);
      push_ins(0, 16'h4440, 0); push_ins(0, 16'h5550, 0);
      cyc(1, 0, 0, 0);
      cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);
      cyc(0, 1, 0, 0);
      chk("R3 half of long held back", insn_valid, 0);
      cyc(1, 1, 0, 0);
      cyc(0, 0, 0, 0);
      chk("R3 long complete", insn_valid, 1);
      chk("R2 long assembled", insn_data, 32'hB002A001);

      // Full window: third word without consume is dropped
      do_flush(0, 0, 0);
      repeat (12) push_ins(0, 16'($urandom), 0);
      cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
      cyc(1, 0, 0, 0);
      chk("R7 full window no request", fetch_req, 0);
      repeat (8) cyc(0, 1, 0, 0);
      cyc(0, 0, 0, 0);
      chk("R7 dropped word left no trace", insn_valid, 0);

      // Flush offset 3: only the last halfword of the next word is kept
      do_flush(3, 0, 0);
      push_ins(1, 16'hC0C1, 16'hD0D2);
      repeat (4) push_ins(0, 16'($urandom), 0);
      cyc(1, 0, 0, 0);
      cyc(0, 0, 0, 0);
      chk("R9 skipped halfwords, long pending", insn_valid, 0);
      cyc(1, 0, 0, 0);
      cyc(0, 0, 0, 0);
      chk("R9 first instruction after offset", insn_data, 32'hD0D2C0C1);

      // Flush together with fetch and consume
      cyc(0, 0, 0, 0);
      do_flush(1, 1, 1);
      cyc(0, 0, 0, 0);
      chk("R8 empty after flush", insn_valid, 0);

      // Constrained random stream
      for (int n = 0; n < 20000; n++) begin
         bit fv, cons;
         fv   = (prev_req && ($urandom % 4 != 0)) || ($urandom % 20 == 0);
         cons = ($urandom % 10) < 7;
         if ($urandom % 400 == 0)
            do_flush(int'($urandom % 4), fv, cons);
         else
            cyc(fv, cons, 0, 0);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule